// File: doc/BRIEF.md
# Rotating Register Rename Unit

This block maps the logical register numbers an instruction names onto physical register slots, so that a software-pipelined loop can reuse the same register names on every iteration while each iteration actually works on fresh storage. Three register files are handled side by side: a 128-entry general file whose rotating part has a size set by an input, a 128-entry floating-point file, and a 64-entry one-bit predicate file. The lower, static part of each file always maps straight through. In the upper part, a logical index is offset by a per-file rotation amount and wrapped modulo the size of that part.

A loop-branch strobe moves all three rotation offsets back by one slot in a single cycle. After that, a value that the previous iteration called r32 is named r33. The same strobe counts down a loop counter and reports whether the branch is taken. It also gives the value and the physical slot for the predicate that rotates into the first rotating position. When the counter is already zero, the branch is reported not-taken and a 0 is produced for the new predicate, so that the stages of the pipelined loop drain away. The rotation still takes place on that branch. Register storage and instruction decode sit outside this block.

Top module: `rot_rename`

## Requirements
- R1: General indices 0–31 map to themselves. A general index at or above 32 + (effective rotating size) also maps to itself.
- R2: For a general index g with 32 ≤ g < 32 + S, the physical index is 32 + ((g − 32 + offset) mod S). S is the rotating-size input, limited to 96 for any larger value. When S is 0, no general register rotates.
- R3: Floating-point indices 0–31 map to themselves. Indices 32–127 map to 32 + ((f − 32 + offset) mod 96).
- R4: Predicate indices 1–15 map to themselves. Indices 16–63 map to 16 + ((p − 16 + offset) mod 48).
- R5: When the predicate index is 0, `pr_one` is 1 and `pr_phys` is 0. The rotating predicate slot can never be slot 0, so a predicate write cannot reach it.
- R6: Each clock edge with `loop_br` high lowers every rotation offset by one, modulo the size of its region. After such an edge, logical 33 of each file resolves to the slot that logical 32 resolved to before the edge (16 and 17 for predicates).
- R7: While the loop counter is nonzero, `loop_br` gives `br_taken` = 1 and `rot_pred_val` = 1 in the same cycle, and the counter decrements at the edge.
- R8: While the loop counter is zero, `loop_br` gives `br_taken` = 0 and `rot_pred_val` = 0. The counter stays at zero, and the rotation of R6 still happens.
- R9: `lc_load` loads `lc_value` into the counter at the edge. If `lc_load` and `loop_br` are both high, the load sets the counter while the rotation of R6 still happens.
- R10: Synchronous reset clears all three offsets and the counter. Afterwards every index maps to itself and `br_taken` is 0.
- R11: `rot_pred_slot` is the physical slot that logical predicate 16 names after the pending rotation. This is 16 + ((offset − 1) mod 48).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gr_rot_size | input | 7 | Number of rotating general registers (limited to 96) |
| gr_log | input | 7 | Logical general register index |
| fr_log | input | 7 | Logical floating-point register index |
| pr_log | input | 6 | Logical predicate index |
| loop_br | input | 1 | Loop-branch strobe: rotate and count down |
| lc_load | input | 1 | Load the loop counter |
| lc_value | input | 16 | Value for a counter load |
| gr_phys | output | 7 | Physical general register index |
| fr_phys | output | 7 | Physical floating-point register index |
| pr_phys | output | 6 | Physical predicate index |
| pr_one | output | 1 | Predicate index 0 is addressed (reads as constant 1) |
| br_taken | output | 1 | Loop branch taken (counter was nonzero) |
| rot_pred_val | output | 1 | Value for the predicate that rotates in |
| rot_pred_slot | output | 6 | Physical slot of the predicate that rotates in |

## Verification
The assertions assume that `gr_rot_size` changes only while the general offset is zero, so the general offset always stays below the effective size. The bench keeps to this by programming the size directly after a reset and holding it steady until the next reset. The counter properties assume `lc_value` is steady around the load edge. The bench drives every input on the falling edge, so this holds.

// File: rtl/rot_rename.sv
module rot_rename #(
  parameter int GR_N      = 128,
  parameter int GR_STATIC = 32,
  parameter int FR_N      = 128,
  parameter int FR_STATIC = 32,
  parameter int PR_N      = 64,
  parameter int PR_STATIC = 16,
  parameter int LC_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(GR_N)-1:0] gr_rot_size,
  input  logic [$clog2(GR_N)-1:0] gr_log,
  input  logic [$clog2(FR_N)-1:0] fr_log,
  input  logic [$clog2(PR_N)-1:0] pr_log,
  input  logic                    loop_br,
  input  logic                    lc_load,
  input  logic [LC_W-1:0]         lc_value,
  output logic [$clog2(GR_N)-1:0] gr_phys,
  output logic [$clog2(FR_N)-1:0] fr_phys,
  output logic [$clog2(PR_N)-1:0] pr_phys,
  output logic                    pr_one,
  output logic                    br_taken,
  output logic                    rot_pred_val,
  output logic [$clog2(PR_N)-1:0] rot_pred_slot
);
  localparam int GW = $clog2(GR_N);
  localparam int FW = $clog2(FR_N);
  localparam int PW = $clog2(PR_N);
  localparam int GROT_MAX = GR_N - GR_STATIC;
  localparam int FROT = FR_N - FR_STATIC;
  localparam int PROT = PR_N - PR_STATIC;

  logic [GW-1:0]   rrb_g, rrb_g_nxt, gsize_eff;
  logic [FW-1:0]   rrb_f, rrb_f_nxt;
  logic [PW-1:0]   rrb_p, rrb_p_nxt;
  logic [LC_W-1:0] lc;
  logic            lc_zero;

  function automatic logic [15:0] remap(input logic [15:0] l, input logic [15:0] b,
                                        input logic [15:0] sz, input logic [15:0] r);
    logic [15:0] s;
    s = l - b + r;
    if (l < b || (l - b) >= sz) return l;
    if (s >= sz) s = s - sz;
    return b + s;
  endfunction

  assign gsize_eff = (gr_rot_size > GW'(GROT_MAX)) ? GW'(GROT_MAX) : gr_rot_size;

  assign rrb_g_nxt = (rrb_g == '0) ? ((gsize_eff == '0) ? '0 : gsize_eff - GW'(1)) : rrb_g - GW'(1);
  assign rrb_f_nxt = (rrb_f == '0) ? FW'(FROT - 1) : rrb_f - FW'(1);
  assign rrb_p_nxt = (rrb_p == '0) ? PW'(PROT - 1) : rrb_p - PW'(1);

  assign gr_phys = GW'(remap(16'(gr_log), 16'(GR_STATIC), 16'(gsize_eff), 16'(rrb_g)));
  assign fr_phys = FW'(remap(16'(fr_log), 16'(FR_STATIC), 16'(FROT), 16'(rrb_f)));
  assign pr_phys = PW'(remap(16'(pr_log), 16'(PR_STATIC), 16'(PROT), 16'(rrb_p)));
  assign pr_one  = (pr_log == '0);

  assign lc_zero       = (lc == '0);
  assign br_taken      = loop_br & ~lc_zero;
  assign rot_pred_val  = loop_br & ~lc_zero;
  assign rot_pred_slot = PW'(PR_STATIC) + rrb_p_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rrb_g <= '0;
      rrb_f <= '0;
      rrb_p <= '0;
    end else if (loop_br) begin
      rrb_g <= rrb_g_nxt;
      rrb_f <= rrb_f_nxt;
      rrb_p <= rrb_p_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      lc <= '0;
    else if (lc_load)             lc <= lc_value;
    else if (loop_br && !lc_zero) lc <= lc - LC_W'(1);
  end

  always_comb begin
    if (gr_log < GW'(GR_STATIC))
      assert_gr_static_R1: assert (gr_phys == gr_log);
  end

  assert_rrb_g_bound_R2: assert property (@(posedge clk) disable iff (rst)
    rrb_g == '0 || rrb_g < gsize_eff);
  assert_rrb_f_bound_R3: assert property (@(posedge clk) disable iff (rst)
    rrb_f < FW'(FROT));
  assert_rrb_p_bound_R4: assert property (@(posedge clk) disable iff (rst)
    rrb_p < PW'(PROT));
  assert_pr0_const_R5: assert property (@(posedge clk) disable iff (rst)
    pr_log == '0 |-> pr_one && pr_phys == '0 && rot_pred_slot != '0);
  assert_lc_dec_R7: assert property (@(posedge clk) disable iff (rst)
    !lc_load && loop_br && br_taken |=> lc == $past(lc) - LC_W'(1));
  assert_lc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !lc_load && !loop_br |=> $stable(lc));
  assert_lc_floor_R8: assert property (@(posedge clk) disable iff (rst)
    !lc_load && loop_br && !br_taken |=> lc == '0);
  assert_lc_load_R9: assert property (@(posedge clk) disable iff (rst)
    lc_load |=> lc == $past(lc_value));
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> rrb_g == '0 && rrb_f == '0 && rrb_p == '0 && lc == '0);
endmodule

// File: tb/sim_rot_rename.sv
module sim_rot_rename;
  logic clk = 1'b0, rst = 1'b0;
  logic [6:0] gr_rot_size = '0, gr_log = '0, fr_log = '0;
  logic [5:0] pr_log = '0;
  logic loop_br = 1'b0, lc_load = 1'b0;
  logic [15:0] lc_value = '0;
  logic [6:0] gr_phys, fr_phys;
  logic [5:0] pr_phys, rot_pred_slot;
  logic pr_one, br_taken, rot_pred_val;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rot_rename u0 (.clk(clk), .rst(rst), .gr_rot_size(gr_rot_size), .gr_log(gr_log),
    .fr_log(fr_log), .pr_log(pr_log), .loop_br(loop_br), .lc_load(lc_load),
    .lc_value(lc_value), .gr_phys(gr_phys), .fr_phys(fr_phys), .pr_phys(pr_phys),
    .pr_one(pr_one), .br_taken(br_taken), .rot_pred_val(rot_pred_val),
    .rot_pred_slot(rot_pred_slot));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic probe(input int g, input int f, input int p);
    gr_log = 7'(g); fr_log = 7'(f); pr_log = 6'(p);
    #1;
  endtask

  task automatic do_reset(input int size);
    @(negedge clk); rst = 1'b1; loop_br = 1'b0; lc_load = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0; gr_rot_size = 7'(size);
  endtask

  task automatic rotate(input int n);
    for (int i = 0; i < n; i++) begin
      loop_br = 1'b1;
      @(posedge clk); @(negedge clk);
      loop_br = 1'b0;
    end
  endtask

  task automatic t_reset_state;
    do_reset(96);
    probe(40, 100, 20);
    check("R10 gr identity", gr_phys, 40);
    check("R10 fr identity", fr_phys, 100);
    check("R10 pr identity", pr_phys, 20);
    loop_br = 1'b0; #1;
    check("R10 taken low", br_taken, 0);
    probe(0, 0, 0);
    check("R5 pr_one", pr_one, 1);
    check("R5 pr0 phys", pr_phys, 0);
  endtask

  task automatic t_regions;
    do_reset(8);
    rotate(3);
    probe(10, 20, 7);
    check("R1 gr static", gr_phys, 10);
    check("R3 fr static", fr_phys, 20);
    check("R4 pr static", pr_phys, 7);
    probe(45, 32, 16);
    check("R1 gr beyond size", gr_phys, 45);
    check("R3 fr rotated", fr_phys, 125);
    check("R4 pr rotated", pr_phys, 61);
    probe(32, 40, 20);
    check("R2 gr rotated", gr_phys, 37);
    check("R3 fr wrap", fr_phys, 37);
    check("R4 pr wrap", pr_phys, 17);
    probe(35, 0, 1);
    check("R2 gr wrap", gr_phys, 32);
    check("R4 pr1 static", pr_phys, 1);
  endtask

  task automatic t_shift_r6;
    int g0, f0, p0;
    do_reset(96);
    probe(32, 32, 16);
    g0 = gr_phys; f0 = fr_phys; p0 = pr_phys;
    rotate(1);
    probe(33, 33, 17);
    check("R6 gr r33 = old r32", gr_phys, g0);
    check("R6 fr f33 = old f32", fr_phys, f0);
    check("R6 pr p17 = old p16", pr_phys, p0);
  endtask

  task automatic t_size_limits;
    do_reset(120);
    rotate(1);
    probe(32, 0, 0);
    check("R2 size clamp", gr_phys, 127);
    do_reset(0);
    rotate(2);
    probe(32, 0, 0);
    check("R2 size zero", gr_phys, 32);
  endtask

  task automatic t_counter;
    do_reset(96);
    lc_value = 16'd3; lc_load = 1'b1;
    @(posedge clk); @(negedge clk); lc_load = 1'b0;
    for (int i = 0; i < 5; i++) begin
      loop_br = 1'b1; #1;
      check(i < 3 ? "R7 taken" : "R8 not taken", br_taken, i < 3 ? 1 : 0);
      check(i < 3 ? "R7 pred 1" : "R8 pred 0", rot_pred_val, i < 3 ? 1 : 0);
      @(posedge clk); @(negedge clk); loop_br = 1'b0;
    end
    probe(32, 0, 0);
    check("R8 rotation continues", gr_phys, 123);
  endtask

  task automatic t_load_priority;
    do_reset(96);
    lc_value = 16'd2; lc_load = 1'b1; loop_br = 1'b1; #1;
    check("R9 taken with zero count", br_taken, 0);
    @(posedge clk); @(negedge clk); lc_load = 1'b0; loop_br = 1'b0;
    probe(0, 0, 16);
    check("R9 rotation with load", pr_phys, 63);
    for (int i = 0; i < 3; i++) begin
      loop_br = 1'b1; #1;
      check("R9 loaded count", br_taken, i < 2 ? 1 : 0);
      @(posedge clk); @(negedge clk); loop_br = 1'b0;
    end
  endtask

  task automatic t_slot;
    do_reset(96);
    loop_br = 1'b1; #1;
    check("R11 first slot", rot_pred_slot, 63);
    @(posedge clk); @(negedge clk);
    #1;
    check("R11 second slot", rot_pred_slot, 62);
    @(posedge clk); @(negedge clk); loop_br = 1'b0;
    probe(0, 0, 16);
    check("R11 pr16 lands on slot", pr_phys, 62);
  endtask

  task automatic t_mid_reset;
    do_reset(96);
    lc_value = 16'd9; lc_load = 1'b1;
    @(posedge clk); @(negedge clk); lc_load = 1'b0;
    rotate(2);
    do_reset(96);
    probe(32, 32, 16);
    check("R10 gr cleared", gr_phys, 32);
    check("R10 fr cleared", fr_phys, 32);
    check("R10 pr cleared", pr_phys, 16);
    loop_br = 1'b1; #1;
    check("R10 counter cleared", br_taken, 0);
    @(posedge clk); @(negedge clk); loop_br = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_regions();
    t_shift_r6();
    t_size_limits();
    t_counter();
    t_load_priority();
    t_slot();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule